// File: doc/BRIEF.md
# Chip-Select Access Protection Unit

This block guards one chip-select window. It holds a 16-bit configuration word and judges each bus access on a strobe. Using the access offset inside the window, it decides whether the memory select is driven or the access is refused with a bus error. The window has two parts. The low part is unprotected, and its size is picked by a 2-bit field. The rest of the window is protected. A write-protect control covers the whole window. Separate write-protect and supervisor-only controls cover the protected part.

The block also tells the memory side which strobe style to use. DRAM-style strobes win over flash-type strobes. A combined-bank indication tells the DRAM controller that one bank select spans both bank spaces. All results are registered: the cycle after an access strobe carries either the select or the bus error pulse. A global bus-error enable decides whether a refused access is reported. A refused access never gets a select, whether or not it is reported.

Top module: `cs_guard`

## Requirements
- R1: The configuration word reads back on `cfg_rdata_o`. It resets to 0x0200. It takes `cfg_wdata_i` at the clock edge where `cfg_we_i` is high.
- R2: While the enable bit (bit 0) is clear, no strobe produces `sel_o`, `dram_sel_o`, `flash_sel_o` or `berr_o`.
- R3: Bits 12:11 set the unprotected size: 0 is 32K, 1 is 64K, 2 is 128K and 3 is 256K. An offset below that size is unprotected. Any offset at or above it is protected.
- R4: With bit 15 set, a write anywhere in the window is a violation. Reads are still allowed.
- R5: With bit 14 set, a user-mode access (`acc_super_i` low) to the protected part is a violation. Supervisor accesses to it are allowed. User accesses to the unprotected part are allowed.
- R6: With bit 13 set, a write to the protected part is a violation. Writes to the unprotected part are allowed.
- R7: On a violation, `sel_o` stays low. If `berr_en_i` was high at the strobe, `berr_o` pulses high for exactly the one cycle after the strobe. If it was low, no error is raised.
- R8: A permitted access drives `sel_o` high for exactly the one cycle after its strobe.
- R9: `dram_sel_o` accompanies `sel_o` when bit 9 is set. `flash_sel_o` accompanies `sel_o` only when bit 8 is set and bit 9 is clear.
- R10: `combined_o` is high exactly when bits 10, 9 and 0 of the current configuration word are all set.
- R11: A strobe in the same cycle as a configuration write is judged against the configuration held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Current configuration word |
| acc_valid_i | input | 1 | Access strobe |
| acc_offset_i | input | AW (19) | Byte offset of the access inside the window |
| acc_write_i | input | 1 | Access is a write |
| acc_super_i | input | 1 | Access is in supervisor mode |
| berr_en_i | input | 1 | Global bus-error enable |
| sel_o | output | 1 | Memory select for a permitted access |
| dram_sel_o | output | 1 | Select uses DRAM-style strobes |
| flash_sel_o | output | 1 | Select uses flash-type strobes |
| combined_o | output | 1 | One bank select spans both DRAM bank spaces |
| berr_o | output | 1 | Bus error pulse for a refused access |

## Verification
A configuration write and an access strobe can land in the same cycle. The bench provokes this by raising `cfg_we_i` and `acc_valid_i` together. In one case the new word would forbid the access. In the other, the old word forbids it and the new word would allow it. The result is judged against a model that updates its own copy of the word only after it has judged the strobe. A permitted result must therefore follow the old word, and the very next strobe must follow the new one.

// File: rtl/cs_guard_pkg.sv
package cs_guard_pkg;

  typedef struct packed {
    logic       ro_all;     // 15
    logic       sup_only;   // 14
    logic       ro_prot;    // 13
    logic [1:0] usz;        // 12:11
    logic       merge;      // 10
    logic       dram;       // 9
    logic       flash;      // 8
    logic [6:0] misc;       // 7:1, held only
    logic       en;         // 0
  } cs_cfg_t;

  localparam cs_cfg_t CFG_RST = cs_cfg_t'(16'h0200);
  localparam int unsigned NUM_SIZES = 4;

endpackage

// File: rtl/cs_guard_cfg_reg.sv
module cs_guard_cfg_reg
  import cs_guard_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  cs_cfg_t wdata_i,
  output cs_cfg_t q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= CFG_RST;
    else if (we_i) q_o <= wdata_i;
  end

  // R1
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));

endmodule

// File: rtl/cs_guard_region.sv
module cs_guard_region
  import cs_guard_pkg::*;
#(
  parameter int unsigned AW         = 19,
  parameter int unsigned BASE_SHIFT = 15  // log2 of smallest unprotected size
) (
  input  logic [AW-1:0] offset_i,
  input  logic [1:0]    usz_i,
  output logic          prot_o
);

  localparam int unsigned LW = AW + 1;

  logic [LW-1:0] lim [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lim
    assign lim[k] = LW'(1) << (BASE_SHIFT + k);
  end

  assign prot_o = ({1'b0, offset_i} >= lim[usz_i]);

endmodule

// File: rtl/cs_guard_check.sv
module cs_guard_check (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic write_i,
  input  logic super_i,
  input  logic prot_i,
  input  logic berr_en_i,
  input  logic en_i,
  input  logic ro_all_i,
  input  logic sup_only_i,
  input  logic ro_prot_i,
  input  logic dram_i,
  input  logic flash_i,
  output logic sel_o,
  output logic dram_sel_o,
  output logic flash_sel_o,
  output logic berr_o
);

  logic hit, viol, grant;

  always_comb begin
    hit   = valid_i & en_i;
    viol  = (ro_all_i & write_i)
          | (prot_i & sup_only_i & ~super_i)
          | (prot_i & ro_prot_i & write_i);
    grant = hit & ~viol;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o       <= 1'b0;
      dram_sel_o  <= 1'b0;
      flash_sel_o <= 1'b0;
      berr_o      <= 1'b0;
    end else begin
      sel_o       <= grant;
      dram_sel_o  <= grant & dram_i;
      flash_sel_o <= grant & flash_i & ~dram_i;   // DRAM wins
      berr_o      <= hit & viol & berr_en_i;
    end
  end

  // R7
  sel_berr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_o && berr_o));

  // R7
  berr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> $past(valid_i && en_i && berr_en_i));

  // R2
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !en_i) |=> (!sel_o && !berr_o));

  // R8
  sel_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> $past(valid_i));

  // R9
  dram_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_sel_o |-> (sel_o && !dram_sel_o));

endmodule

// File: rtl/cs_guard.sv
module cs_guard
  import cs_guard_pkg::*;
#(
  parameter int unsigned AW         = 19,
  parameter int unsigned BASE_SHIFT = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [15:0]   cfg_wdata_i,
  output logic [15:0]   cfg_rdata_o,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_offset_i,
  input  logic          acc_write_i,
  input  logic          acc_super_i,
  input  logic          berr_en_i,
  output logic          sel_o,
  output logic          dram_sel_o,
  output logic          flash_sel_o,
  output logic          combined_o,
  output logic          berr_o
);

  cs_cfg_t cfg_q;
  logic    prot;

  cs_guard_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cs_cfg_t'(cfg_wdata_i)),
    .q_o     (cfg_q)
  );

  cs_guard_region #(.AW(AW), .BASE_SHIFT(BASE_SHIFT)) u_region (
    .offset_i (acc_offset_i),
    .usz_i    (cfg_q.usz),
    .prot_o   (prot)
  );

  cs_guard_check u_check (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (acc_valid_i),
    .write_i     (acc_write_i),
    .super_i     (acc_super_i),
    .prot_i      (prot),
    .berr_en_i   (berr_en_i),
    .en_i        (cfg_q.en),
    .ro_all_i    (cfg_q.ro_all),
    .sup_only_i  (cfg_q.sup_only),
    .ro_prot_i   (cfg_q.ro_prot),
    .dram_i      (cfg_q.dram),
    .flash_i     (cfg_q.flash),
    .sel_o       (sel_o),
    .dram_sel_o  (dram_sel_o),
    .flash_sel_o (flash_sel_o),
    .berr_o      (berr_o)
  );

  assign cfg_rdata_o = cfg_q;
  assign combined_o  = cfg_q.merge & cfg_q.dram & cfg_q.en;

  // R10
  combined_needs_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    combined_o |-> (cfg_rdata_o[9] && cfg_rdata_o[0]));

endmodule

// File: tb/cs_guard_tb_top.sv
module cs_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_offset = '0;
  logic          acc_write = 1'b0;
  logic          acc_super = 1'b0;
  logic          berr_en = 1'b0;
  logic          sel, dram_sel, flash_sel, combined, berr;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_guard #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .acc_valid_i(acc_valid), .acc_offset_i(acc_offset),
    .acc_write_i(acc_write), .acc_super_i(acc_super), .berr_en_i(berr_en),
    .sel_o(sel), .dram_sel_o(dram_sel), .flash_sel_o(flash_sel),
    .combined_o(combined), .berr_o(berr)
  );

  // behavioural reference
  int m_cfg = 'h0200;
  bit e_sel, e_dram, e_flash, e_berr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 'h0200;
      e_sel = 0; e_dram = 0; e_flash = 0; e_berr = 0;
    end else begin
      int lim;
      bit prot, viol, hit;
      lim  = 32768 * (1 << ((m_cfg >> 11) & 3));
      prot = (int'(acc_offset) >= lim);
      viol = (m_cfg[15] && acc_write) || (prot && m_cfg[14] && !acc_super) ||
             (prot && m_cfg[13] && acc_write);
      hit  = acc_valid && m_cfg[0];
      e_sel   = hit && !viol;
      e_berr  = hit && viol && berr_en;
      e_dram  = e_sel && m_cfg[9];
      e_flash = e_sel && m_cfg[8] && !m_cfg[9];
      if (cfg_we) m_cfg = int'(cfg_wdata);  // R11: judged before update
    end
  end

  task automatic chk(string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0h exp=%0h t=%0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("cfg_rdata", cfg_rdata, m_cfg & 'hFFFF);
      chk("sel", sel, e_sel);
      chk("berr", berr, e_berr);
      chk("dram_sel", dram_sel, e_dram);
      chk("flash_sel", flash_sel, e_flash);
      chk("combined", combined, m_cfg[10] && m_cfg[9] && m_cfg[0]);
    end
  end

  task automatic idle(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(int off, bit wr, bit sup, bit be);
    acc_valid = 1'b1; acc_offset = AW'(off); acc_write = wr;
    acc_super = sup; berr_en = be;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset word checked every cycle while idle
    cur_req = "R1"; idle(2);
    total++;
    if (cfg_rdata !== 16'h0200) begin
      bad++; $display("FAIL R1 reset word: got=%0h exp=0200", cfg_rdata);
    end

    // R2 disabled: no response even with protection bits and error enable
    cur_req = "R2";
    wcfg(16'hE000);
    acc(0, 1, 0, 1); acc('h70000, 0, 0, 1); acc('h10, 0, 1, 1); idle(2);

    // R8 permitted read, plain static memory
    cur_req = "R8";
    wcfg(16'h0001);
    acc(0, 0, 0, 1); idle(1); acc('h7FFFF, 1, 0, 1); idle(2);

    // R3/R6 boundaries for each size
    for (int s = 0; s < 4; s++) begin
      int lim;
      lim = 32768 << s;
      cur_req = "R3";
      wcfg(16'h2001 | 16'(s << 11));
      acc(lim - 1, 1, 1, 1); idle(1);
      cur_req = "R6";
      acc(lim, 1, 1, 1); idle(1);
      acc(lim, 0, 1, 1); idle(1);
    end

    // R5 supervisor-only protected part
    cur_req = "R5";
    wcfg(16'h4001);
    acc('h9000, 0, 0, 1); acc('h9000, 0, 1, 1); acc('h100, 0, 0, 1); idle(2);

    // R4 whole window read-only
    cur_req = "R4";
    wcfg(16'h8001);
    acc(0, 1, 1, 1); acc(0, 0, 0, 1); acc('h50000, 1, 1, 1); idle(2);

    // R7 violations with error reporting off, back-to-back errors
    cur_req = "R7";
    acc(0, 1, 1, 0); idle(1);
    acc(0, 1, 1, 1); acc(4, 1, 1, 1); acc(8, 1, 1, 0); idle(2);

    // R9 strobe style priority
    cur_req = "R9";
    wcfg(16'h0301); acc(0, 0, 1, 1); idle(1);
    wcfg(16'h0101); acc(0, 1, 1, 1); idle(1);
    wcfg(16'h0201); acc(0, 0, 0, 1); idle(2);

    // R10 combine indication
    cur_req = "R10";
    wcfg(16'h0601); idle(1);
    wcfg(16'h0401); idle(1);
    wcfg(16'h0600); idle(1);

    // R11 config write and strobe in one cycle
    cur_req = "R11";
    wcfg(16'h0001);
    cfg_we = 1'b1; cfg_wdata = 16'h2001;
    acc_valid = 1'b1; acc_offset = AW'('h9000); acc_write = 1'b1;
    acc_super = 1'b1; berr_en = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    acc('h9000, 1, 1, 1); idle(1);
    cfg_we = 1'b1; cfg_wdata = 16'h0001;
    acc('h9000, 1, 1, 1);
    cfg_we = 1'b0;
    acc('h9000, 1, 1, 1); idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule